// File: doc/BRIEF.md
# Text-Mode Character Video Generator

This block produces the monochrome pixel stream and the sync timing for a 40-column by 25-row text screen shown on a composite television. It runs from an 8 MHz pixel clock, and every line lasts 512 clocks. An input selects a 262-line field or a 312-line field. The text window sits in the middle of both axes.

For each character cell the block places a video RAM address, which it builds from the row and the column. It then turns the returned character code into a character ROM address from the code and the scan line inside the cell. The ROM byte goes into an 8-bit shifter and leaves one pixel per clock, most significant bit first, with no gap between neighbouring bytes.

The block has no separate graphics mode. A glyph set made of solid sub-block patterns gives a coarse bitmap through the same hardware. Both memories are external and synchronous, with a read latency of one clock.

Top module: `txt_video_gen`

## Requirements
- R1: A line lasts H_TOTAL = 512 clocks, and `hsync_no` is low for the first 38 clocks of every line.
- R2: A field has 262 lines while `pal_mode_i` = 0 and 312 lines while it is 1. `vsync_no` is low for the first 3 lines of each field.
- R3: `csync_no` is low exactly when `hsync_no` or `vsync_no` is low.
- R4: `active_o` is high for line clocks 96 to 415 on 200 consecutive lines. These start at line (field length − 200)/2, which is 31 for 262 lines and 56 for 312 lines. It is never high while either sync is low.
- R5: `video_o` is 0 whenever `active_o` is 0.
- R6: On active lines, during line clocks 88 to 407, `ram_addr_o` = row·40 + (clock − 88)/8, where row = (line − first active line)/8. The address is held for each aligned group of 8 clocks.
- R7: `rom_addr_o` = code·8 + scan, where code is `ram_data_i` and scan = (line − first active line) mod 8. It is therefore correct from the second clock of each 8-clock fetch group.
- R8: Pixel k (0..7) of column c appears on `video_o` at line clock 96 + 8c + k and equals bit 7 − k of the ROM byte for that column and scan line. Bytes follow one another with no gap.
- R9: If `pal_mode_i` selects a field length that the current line number already exceeds, the field ends at the end of the current line.
- R10: During reset the block is at line 0, clock 0: `hsync_no`, `vsync_no` and `csync_no` are low, and `active_o` and `video_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pal_mode_i | input | 1 | 0: 262-line field, 1: 312-line field |
| ram_addr_o | output | AW (10) | Text RAM address |
| ram_data_i | input | CODE_W (8) | Character code, one clock after address |
| rom_addr_o | output | CODE_W+LB (11) | Character ROM address |
| rom_data_i | input | CELL_W (8) | Glyph row byte, one clock after address |
| video_o | output | 1 | Serial pixel output |
| active_o | output | 1 | Visible-area indicator |
| hsync_no | output | 1 | Horizontal sync, active low |
| vsync_no | output | 1 | Vertical sync, active low |
| csync_no | output | 1 | Composite sync, active low |

## Verification
The assertions take two things for granted. First, reset is asserted before the first clock. Second, `pal_mode_i` changes only between clock edges, so the counters never see it change partway through an edge. The bench drives every input on the falling clock edge. Its RAM and ROM models register the address on the rising edge, which gives the fixed one-clock latency that the shifter load timing depends on. Mode changes are made either at a field boundary or at one chosen line beyond the shorter field length, so the field-truncation case is reached on purpose.

// File: rtl/txt_video_pkg.sv
package txt_video_pkg;
  localparam int H_TOTAL_D    = 512;
  localparam int H_SYNC_D     = 38;
  localparam int COLS_D       = 40;
  localparam int ROWS_D       = 25;
  localparam int CELL_W_D     = 8;
  localparam int CELL_H_D     = 8;
  localparam int CODE_W_D     = 8;
  localparam int NTSC_LINES_D = 262;
  localparam int PAL_LINES_D  = 312;
  localparam int V_SYNC_D     = 3;
endpackage

// File: rtl/vid_timing.sv
module vid_timing #(
  parameter int H_TOTAL    = 512,
  parameter int H_SYNC     = 38,
  parameter int H_ACT_LEN  = 320,
  parameter int V_ACT_LEN  = 200,
  parameter int NTSC_LINES = 262,
  parameter int PAL_LINES  = 312,
  parameter int V_SYNC     = 3,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(PAL_LINES),
  localparam int LW = $clog2(V_ACT_LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pal_mode_i,
  output logic [HW-1:0] h_o,
  output logic          h_vis_o,
  output logic          vis_line_o,
  output logic [LW-1:0] line_idx_o,
  output logic          hsync_no,
  output logic          vsync_no
);
  localparam int H_ACT   = (H_TOTAL - H_ACT_LEN) / 2;
  localparam int V_ST_N  = (NTSC_LINES - V_ACT_LEN) / 2;
  localparam int V_ST_P  = (PAL_LINES - V_ACT_LEN) / 2;

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q, v_last, v_start, v_rel;

  always_comb begin
    v_last  = pal_mode_i ? VW'(PAL_LINES - 1) : VW'(NTSC_LINES - 1);
    v_start = pal_mode_i ? VW'(V_ST_P) : VW'(V_ST_N);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (h_q == HW'(H_TOTAL - 1)) begin
      h_q <= '0;
      v_q <= (v_q >= v_last) ? '0 : v_q + 1'b1;  // >= handles a shortened field
    end else begin
      h_q <= h_q + 1'b1;
    end
  end

  assign v_rel      = v_q - v_start;
  assign h_o        = h_q;
  assign h_vis_o    = (h_q >= HW'(H_ACT)) && (h_q < HW'(H_ACT + H_ACT_LEN));
  assign vis_line_o = (v_q >= v_start) && (v_rel < VW'(V_ACT_LEN));
  assign line_idx_o = LW'(v_rel);
  assign hsync_no   = !(h_q < HW'(H_SYNC));
  assign vsync_no   = !(v_q < VW'(V_SYNC));

  assert_v_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_q != '0) |-> $stable(v_q));
endmodule

// File: rtl/vid_fetch.sv
module vid_fetch #(
  parameter int H_TOTAL = 512,
  parameter int COLS    = 40,
  parameter int ROWS    = 25,
  parameter int CELL_W  = 8,
  parameter int CELL_H  = 8,
  parameter int CODE_W  = 8,
  localparam int HW = $clog2(H_TOTAL),
  localparam int LW = $clog2(ROWS * CELL_H),
  localparam int AW = $clog2(COLS * ROWS),
  localparam int CB = $clog2(CELL_W),
  localparam int LB = $clog2(CELL_H)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [HW-1:0]        h_i,
  input  logic                 vis_line_i,
  input  logic [LW-1:0]        line_idx_i,
  input  logic [CODE_W-1:0]    ram_data_i,
  output logic [AW-1:0]        ram_addr_o,
  output logic [CODE_W+LB-1:0] rom_addr_o,
  output logic                 load_o
);
  // fetch for a column starts one cell before its first pixel
  localparam int F_START = (H_TOTAL - COLS * CELL_W) / 2 - CELL_W;
  localparam int F_END   = F_START + COLS * CELL_W;

  logic [HW-1:0] rel, col;
  logic [LW-1:0] row;
  logic          in_win;

  assign rel    = h_i - HW'(F_START);
  assign col    = rel >> CB;
  assign row    = line_idx_i >> LB;
  assign in_win = vis_line_i && (h_i >= HW'(F_START)) && (h_i < HW'(F_END));

  assign ram_addr_o = in_win ? AW'(int'(row) * COLS + int'(col)) : '0;
  assign rom_addr_o = {ram_data_i, line_idx_i[LB-1:0]};
  assign load_o     = (rel[CB-1:0] == CB'(CELL_W - 1));

  assert_addr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_win && rel[CB-1:0] != CB'(CELL_W - 1)) |=> $stable(ram_addr_o));
endmodule

// File: rtl/vid_shifter.sv
module vid_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         en_i,
  output logic         pix_o
);
  logic [W-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shift_q <= '0;
    else if (load_i) shift_q <= data_i;
    else             shift_q <= {shift_q[W-2:0], 1'b0};
  end

  assign pix_o = shift_q[W-1] & en_i;

  assert_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (shift_q == $past(data_i)));
endmodule

// File: rtl/txt_video_gen.sv
module txt_video_gen
  import txt_video_pkg::*;
#(
  parameter int H_TOTAL    = H_TOTAL_D,
  parameter int H_SYNC     = H_SYNC_D,
  parameter int COLS       = COLS_D,
  parameter int ROWS       = ROWS_D,
  parameter int CELL_W     = CELL_W_D,
  parameter int CELL_H     = CELL_H_D,
  parameter int CODE_W     = CODE_W_D,
  parameter int NTSC_LINES = NTSC_LINES_D,
  parameter int PAL_LINES  = PAL_LINES_D,
  parameter int V_SYNC     = V_SYNC_D,
  localparam int AW = $clog2(COLS * ROWS),
  localparam int LB = $clog2(CELL_H)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pal_mode_i,
  output logic [AW-1:0]        ram_addr_o,
  input  logic [CODE_W-1:0]    ram_data_i,
  output logic [CODE_W+LB-1:0] rom_addr_o,
  input  logic [CELL_W-1:0]    rom_data_i,
  output logic                 video_o,
  output logic                 active_o,
  output logic                 hsync_no,
  output logic                 vsync_no,
  output logic                 csync_no
);
  localparam int HW = $clog2(H_TOTAL);
  localparam int LW = $clog2(ROWS * CELL_H);

  logic [HW-1:0] h;
  logic [LW-1:0] line_idx;
  logic          h_vis, vis_line, load;

  vid_timing #(
    .H_TOTAL(H_TOTAL), .H_SYNC(H_SYNC), .H_ACT_LEN(COLS * CELL_W),
    .V_ACT_LEN(ROWS * CELL_H), .NTSC_LINES(NTSC_LINES),
    .PAL_LINES(PAL_LINES), .V_SYNC(V_SYNC)
  ) u_timing (
    .clk_i, .rst_ni, .pal_mode_i,
    .h_o(h), .h_vis_o(h_vis), .vis_line_o(vis_line), .line_idx_o(line_idx),
    .hsync_no, .vsync_no
  );

  vid_fetch #(
    .H_TOTAL(H_TOTAL), .COLS(COLS), .ROWS(ROWS), .CELL_W(CELL_W),
    .CELL_H(CELL_H), .CODE_W(CODE_W)
  ) u_fetch (
    .clk_i, .rst_ni, .h_i(h), .vis_line_i(vis_line), .line_idx_i(line_idx),
    .ram_data_i, .ram_addr_o, .rom_addr_o, .load_o(load)
  );

  vid_shifter #(.W(CELL_W)) u_shift (
    .clk_i, .rst_ni, .load_i(load), .data_i(rom_data_i),
    .en_i(active_o), .pix_o(video_o)
  );

  assign active_o = h_vis & vis_line;
  assign csync_no = hsync_no & vsync_no;

  assert_sync_blank_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hsync_no || !vsync_no) |-> !active_o);
endmodule

// File: tb/txt_video_gen_tb.sv
`timescale 1ns/1ps
module txt_video_gen_tb_top;
  localparam int CLK_PERIOD = 125;
  localparam int ROWS_B = 4;
  localparam int NTSC_B = 46;
  localparam int PAL_B  = 56;
  localparam int AW = $clog2(40 * ROWS_B);

  logic clk = 1'b0, rst_n = 1'b0, pal = 1'b0;
  logic [AW-1:0] ram_addr;
  logic [10:0]   rom_addr;
  logic [7:0]    ram_q, rom_q;
  logic video, active, hs_n, vs_n, cs_n;
  int checks = 0, errors = 0, pat = 0;
  int hb, vb;

  always #(CLK_PERIOD/2) clk = ~clk;

  txt_video_gen #(.ROWS(ROWS_B), .NTSC_LINES(NTSC_B), .PAL_LINES(PAL_B)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pal_mode_i(pal),
    .ram_addr_o(ram_addr), .ram_data_i(ram_q),
    .rom_addr_o(rom_addr), .rom_data_i(rom_q),
    .video_o(video), .active_o(active),
    .hsync_no(hs_n), .vsync_no(vs_n), .csync_no(cs_n)
  );

  function automatic logic [7:0] ram_f(int a);
    return (pat != 0) ? (8'h80 | 8'(a * 13)) : 8'(a * 7 + 3);
  endfunction

  // codes with bit 7 set: solid 2x4 sub-block glyphs
  function automatic logic [7:0] rom_f(logic [7:0] code, int ln);
    int sub;
    if (code[7]) begin
      sub = ln / 2;
      return {{4{code[sub*2]}}, {4{code[sub*2+1]}}};
    end
    return code ^ 8'(ln * 37);
  endfunction

  always_ff @(posedge clk) begin
    ram_q <= ram_f(int'(ram_addr));
    rom_q <= rom_f(rom_addr[10:3], int'(rom_addr[2:0]));
  end

  // reference position from the stated line and field lengths
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin hb <= 0; vb <= 0; end
    else if (hb == 511) begin
      hb <= 0;
      vb <= (vb >= (pal ? PAL_B : NTSC_B) - 1) ? 0 : vb + 1;
    end else hb <= hb + 1;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(hs_n == 1'b0, "R10", "hsync in reset", hs_n, 0);
    chk(vs_n == 1'b0, "R10", "vsync in reset", vs_n, 0);
    chk(cs_n == 1'b0, "R10", "csync in reset", cs_n, 0);
    chk(active == 1'b0 && video == 1'b0, "R10", "active/video in reset",
        int'(active) + int'(video), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_frame(string name);
    int err[8], fa[8], fe[8];
    string tags[8] = '{"R1", "R2", "R3", "R4", "R5", "R8", "R6", "R7"};
    int n, vs0, prev_vs;
    while (!(hb == 0 && vb == 0)) @(negedge clk);
    n = (pal ? PAL_B : NTSC_B) * 512;
    vs0 = ((pal ? PAL_B : NTSC_B) - ROWS_B * 8) / 2;
    for (int i = 0; i < 8; i++) begin err[i] = 0; fa[i] = 0; fe[i] = 0; end
    prev_vs = 1;
    for (int i = 0; i < n; i++) begin
      int li, row, ln, ea, eh, ev, ra, ph;
      logic [7:0] b;
      eh = (hb >= 38) ? 1 : 0;
      ev = (vb >= 3) ? 1 : 0;
      li = vb - vs0; row = li / 8; ln = li % 8;
      ea = (vb >= vs0 && li < ROWS_B * 8 && hb >= 96 && hb < 416) ? 1 : 0;
      if (hs_n != eh) begin if (err[0] == 0) begin fa[0] = hs_n; fe[0] = eh; end err[0]++; end
      if (vs_n != ev) begin if (err[1] == 0) begin fa[1] = vs_n; fe[1] = ev; end err[1]++; end
      if (cs_n != (eh & ev)) begin if (err[2] == 0) begin fa[2] = cs_n; fe[2] = eh & ev; end err[2]++; end
      if (active != ea) begin if (err[3] == 0) begin fa[3] = active; fe[3] = ea; end err[3]++; end
      if (!active && video) begin if (err[4] == 0) begin fa[4] = 1; fe[4] = 0; end err[4]++; end
      if (ea == 1) begin
        b = rom_f(ram_f(row * 40 + (hb - 96) / 8), ln);
        if (video != b[7 - (hb - 96) % 8]) begin
          if (err[5] == 0) begin fa[5] = video; fe[5] = b[7 - (hb - 96) % 8]; end err[5]++;
        end
      end
      if (vb >= vs0 && li < ROWS_B * 8 && hb >= 88 && hb < 408) begin
        ra = row * 40 + (hb - 88) / 8;
        ph = (hb - 88) % 8;
        if (int'(ram_addr) != ra) begin
          if (err[6] == 0) begin fa[6] = ram_addr; fe[6] = ra; end err[6]++;
        end
        if (ph != 0 && int'(rom_addr) != int'(ram_f(ra)) * 8 + ln) begin
          if (err[7] == 0) begin fa[7] = rom_addr; fe[7] = int'(ram_f(ra)) * 8 + ln; end err[7]++;
        end
      end
      if (i > 0 && prev_vs == 1 && vs_n == 1'b0) begin
        if (err[1] == 0) begin fa[1] = i; fe[1] = n; end err[1]++;
      end
      prev_vs = vs_n;
      @(negedge clk);
    end
    for (int i = 0; i < 8; i++)
      chk(err[i] == 0, tags[i], name, fa[i], fe[i]);
    chk(prev_vs == 1 && vs_n == 1'b0, "R2", {name, " field length"},
        int'(vs_n), 0);
  endtask

  task automatic t_shorten();
    while (!(hb == 0 && vb == 50)) @(negedge clk);
    pal = 1'b0;
    repeat (511) @(negedge clk);
    chk(vs_n == 1'b1, "R9", "still in line 50 before wrap", vs_n, 1);
    @(negedge clk);
    chk(vs_n == 1'b0 && hs_n == 1'b0, "R9", "field restarts after shortening",
        int'(vs_n), 0);
  endtask

  initial begin
    t_reset();
    t_frame("ntsc text");
    pat = 1;
    t_frame("ntsc blocks");
    pal = 1'b1;
    pat = 0;
    t_frame("pal text");
    t_shorten();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule